// File: doc/BRIEF.md
# Three-Level Sleep Sequencer

This block decides when the processor core, its peripherals and the clock sources run. Out of reset it sits in the running mode. Software selects a sleep level on a two-bit request and pulses an enter strobe. The sequencer then gates the clock resources that belong to that level. Each level can be woken only by its own set of events.

There are three levels.

- **Light sleep** stops only the core clock. Each peripheral keeps its clock according to its own enable bit. A request from a clocked peripheral or a timeout event from the supervision timer ends this level.
- **Medium sleep** stops the core clock and every peripheral clock, but keeps the oscillator and PLL powered. Only an external wake event ends this level, and the clocks come back on the next cycle.
- **Deep sleep** also turns off the oscillator and PLL. An external wake event restarts them. The clocks stay gated for a parameterised settling count, and only then does the running mode resume.

A hardware reset returns the sequencer to the running mode from any state at any time.

Top module: `lpm_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the mode status is RUN, the core clock enable is high, the oscillator and PLL enables are high, and each peripheral gate equals its enable bit.
- R2: The mode status encodes RUN=0, light sleep=1, medium sleep=2, deep sleep=3. During the oscillator settling window after deep sleep, the status stays 3.
- R3: In RUN, an enter strobe with a nonzero request moves the status to the requested level on the next clock edge. An enter strobe with request 0 leaves the block in RUN.
- R4: In light sleep, the core clock enable is low, the peripheral gates follow their enable bits, and the oscillator and PLL stay enabled.
- R5: Light sleep returns to RUN on the next edge when a peripheral request arrives whose enable bit is set, or when the timeout event arrives. Requests from peripherals whose enable bit is clear, and external wake, are ignored.
- R6: In medium sleep, the core clock and all peripheral gates are off, and the oscillator and PLL stay enabled.
- R7: Medium sleep returns to RUN on the next edge on external wake only. Peripheral requests and timeout events are ignored.
- R8: In deep sleep, the oscillator, PLL, core clock and peripheral gates are all off. Peripheral requests and timeout events are ignored.
- R9: External wake in deep sleep enables the oscillator and PLL on the next edge. The clocks then stay gated for exactly OSC_CYC cycles before RUN resumes.
- R10: If a wake event that would end the requested level is present in the same cycle as the enter strobe, the block stays in RUN.
- R11: Asserting reset in any mode returns the block to RUN immediately, without waiting for a clock edge.
- R12: An enter strobe outside RUN has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset; also acts as a wake source |
| mode_req | input | 2 | Requested sleep level, using the R2 encoding |
| enter | input | 1 | Strobe that starts entry into the level given on mode_req |
| per_clk_en | input | NPER | Clock enable bit for each peripheral |
| per_irq | input | NPER | Interrupt request from each peripheral |
| wdog_evt | input | 1 | Timeout event from the supervision timer |
| ext_wake | input | 1 | External wake event |
| cpu_clk_en | output | 1 | Core clock gate enable |
| per_clk_gate | output | NPER | Gate enable for each peripheral clock |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| mode | output | 2 | Current mode status |

## Verification
The assertions assume that wake inputs and the enter strobe are synchronous to clk and are stable around each rising edge. They also assume OSC_CYC is at least 2, so that the settling window is distinct from the wake cycle. The bench drives every input on the falling edge. It holds wake pulses for exactly one cycle and clears them afterwards. It pulses reset asynchronously only in the middle of a cycle, so every event the checker relies on sees a clean edge.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_STBY = 2'd2,
    MODE_HALT = 2'd3
  } lpm_mode_e;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_IDLE,
    ST_STBY,
    ST_HALT,
    ST_WARM
  } lpm_state_e;

  // Does this event set end the given level?
  function automatic logic level_wake(lpm_mode_e lvl, logic irq_live,
                                      logic wdog, logic ext);
    logic hit;
    case (lvl)
      MODE_IDLE: hit = irq_live | wdog;
      MODE_STBY: hit = ext;
      MODE_HALT: hit = ext;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

  // Status view of an internal state; the settling window reports deep sleep.
  function automatic lpm_mode_e state_to_mode(lpm_state_e s);
    lpm_mode_e m;
    case (s)
      ST_IDLE: m = MODE_IDLE;
      ST_STBY: m = MODE_STBY;
      ST_HALT: m = MODE_HALT;
      ST_WARM: m = MODE_HALT;
      default: m = MODE_RUN;
    endcase
    return m;
  endfunction

  function automatic lpm_state_e mode_to_state(lpm_mode_e m);
    lpm_state_e s;
    case (m)
      MODE_IDLE: s = ST_IDLE;
      MODE_STBY: s = ST_STBY;
      MODE_HALT: s = ST_HALT;
      default:   s = ST_RUN;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/lpm_wake.sv
module lpm_wake
  import lpm_pkg::*;
#(
  parameter int NPER = 4
) (
  input  logic [NPER-1:0] per_irq,
  input  logic [NPER-1:0] per_clk_en,
  input  logic            wdog_evt,
  input  logic            ext_wake,
  input  lpm_mode_e       cur_lvl,
  input  lpm_mode_e       req_lvl,
  output logic            wake_cur,
  output logic            wake_req
);

  logic irq_live;

  // only a peripheral whose clock runs can raise a wake request
  assign irq_live = |(per_irq & per_clk_en);
  assign wake_cur = level_wake(cur_lvl, irq_live, wdog_evt, ext_wake);
  assign wake_req = level_wake(req_lvl, irq_live, wdog_evt, ext_wake);

endmodule

// File: rtl/lpm_warm_cnt.sv
module lpm_warm_cnt #(
  parameter int OSC_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic done
);

  localparam int CW = (OSC_CYC < 2) ? 1 : $clog2(OSC_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (active) cnt_q <= cnt_q + 1'b1;
    else             cnt_q <= '0;
  end

  assign done = active && (cnt_q == CW'(OSC_CYC - 1));

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter,
  input  lpm_mode_e  req_lvl,
  input  logic       wake_cur,
  input  logic       wake_req,
  input  logic       warm_done,
  output lpm_state_e state,
  output logic       enter_ok
);

  lpm_state_e st_q, st_d;

  assign enter_ok = (st_q == ST_RUN) && enter && (req_lvl != MODE_RUN) && !wake_req;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_RUN:  if (enter_ok)  st_d = mode_to_state(req_lvl);
      ST_IDLE: if (wake_cur)  st_d = ST_RUN;
      ST_STBY: if (wake_cur)  st_d = ST_RUN;
      ST_HALT: if (wake_cur)  st_d = ST_WARM;
      ST_WARM: if (warm_done) st_d = ST_RUN;
      default:                st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  assign state = st_q;

endmodule

// File: rtl/lpm_gates.sv
module lpm_gates
  import lpm_pkg::*;
#(
  parameter int NPER = 4
) (
  input  lpm_state_e      state,
  input  logic [NPER-1:0] per_clk_en,
  output logic            cpu_clk_en,
  output logic [NPER-1:0] per_clk_gate,
  output logic            osc_en,
  output logic            pll_en
);

  logic per_on;

  assign per_on     = (state == ST_RUN) || (state == ST_IDLE);
  assign cpu_clk_en = (state == ST_RUN);

  for (genvar g = 0; g < NPER; g++) begin : g_pgate
    assign per_clk_gate[g] = per_on & per_clk_en[g];
  end

  assign osc_en = (state != ST_HALT);
  assign pll_en = (state != ST_HALT);

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int NPER    = 4,
  parameter int OSC_CYC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode_req,
  input  logic            enter,
  input  logic [NPER-1:0] per_clk_en,
  input  logic [NPER-1:0] per_irq,
  input  logic            wdog_evt,
  input  logic            ext_wake,
  output logic            cpu_clk_en,
  output logic [NPER-1:0] per_clk_gate,
  output logic            osc_en,
  output logic            pll_en,
  output logic [1:0]      mode
);

  lpm_state_e state;
  lpm_mode_e  cur_lvl;
  lpm_mode_e  req_lvl;
  logic       wake_cur;
  logic       wake_req;
  logic       warm_done;
  logic       enter_ok;
  logic       warm_active;

  assign req_lvl     = lpm_mode_e'(mode_req);
  assign cur_lvl     = state_to_mode(state);
  assign warm_active = (state == ST_WARM);

  lpm_wake #(.NPER(NPER)) u_wake (
    .per_irq    (per_irq),
    .per_clk_en (per_clk_en),
    .wdog_evt   (wdog_evt),
    .ext_wake   (ext_wake),
    .cur_lvl    (cur_lvl),
    .req_lvl    (req_lvl),
    .wake_cur   (wake_cur),
    .wake_req   (wake_req)
  );

  lpm_warm_cnt #(.OSC_CYC(OSC_CYC)) u_warm (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (warm_active),
    .done   (warm_done)
  );

  lpm_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .enter     (enter),
    .req_lvl   (req_lvl),
    .wake_cur  (wake_cur),
    .wake_req  (wake_req),
    .warm_done (warm_done),
    .state     (state),
    .enter_ok  (enter_ok)
  );

  lpm_gates #(.NPER(NPER)) u_gates (
    .state        (state),
    .per_clk_en   (per_clk_en),
    .cpu_clk_en   (cpu_clk_en),
    .per_clk_gate (per_clk_gate),
    .osc_en       (osc_en),
    .pll_en       (pll_en)
  );

  assign mode = cur_lvl;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int NPER    = 4,
  parameter int OSC_CYC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      mode_req,
  input logic            enter,
  input logic            wdog_evt,
  input logic            ext_wake,
  input logic            cpu_clk_en,
  input logic [NPER-1:0] per_clk_gate,
  input logic            osc_en,
  input logic            pll_en,
  input logic [1:0]      mode,
  input logic            wake_req,
  input logic            enter_ok
);

  int unsigned wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          wcnt <= 0;
    else if (mode == 2'd3 && osc_en)     wcnt <= wcnt + 1;
    else                                 wcnt <= 0;
  end

  // R3
  enter_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_ok |=> (mode == $past(mode_req)));

  // R5
  idle_wdog_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && wdog_evt) |=> (mode == 2'd0 && cpu_clk_en));

  // R6
  stby_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> (!cpu_clk_en && per_clk_gate == '0 && osc_en && pll_en));

  // R7
  stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !ext_wake) |=> (mode == 2'd2));

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !osc_en && !ext_wake) |=> (mode == 2'd3 && !osc_en && !pll_en));

  // R9
  warm_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && osc_en) |-> (wcnt < OSC_CYC && !cpu_clk_en));

  // R9
  warm_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && osc_en && wcnt == OSC_CYC - 1) |=> (mode == 2'd0 && cpu_clk_en));

  // R10
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && enter && wake_req) |=> (mode == 2'd0));

endmodule

bind lpm_ctrl lpm_ctrl_chk #(.NPER(NPER), .OSC_CYC(OSC_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_req     (mode_req),
  .enter        (enter),
  .wdog_evt     (wdog_evt),
  .ext_wake     (ext_wake),
  .cpu_clk_en   (cpu_clk_en),
  .per_clk_gate (per_clk_gate),
  .osc_en       (osc_en),
  .pll_en       (pll_en),
  .mode         (mode),
  .wake_req     (wake_req),
  .enter_ok     (enter_ok)
);

// File: tb/lpm_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_ctrl_tb;

  localparam int NPER = 4;
  localparam int OSC  = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      mode_req = 2'd0;
  logic            enter = 1'b0;
  logic [NPER-1:0] per_clk_en = 4'b0101;
  logic [NPER-1:0] per_irq = '0;
  logic            wdog_evt = 1'b0;
  logic            ext_wake = 1'b0;
  logic            cpu_clk_en;
  logic [NPER-1:0] per_clk_gate;
  logic            osc_en, pll_en;
  logic [1:0]      mode;

  always #10 clk = ~clk;

  lpm_ctrl #(.NPER(NPER), .OSC_CYC(OSC)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .enter(enter),
    .per_clk_en(per_clk_en), .per_irq(per_irq), .wdog_evt(wdog_evt),
    .ext_wake(ext_wake), .cpu_clk_en(cpu_clk_en), .per_clk_gate(per_clk_gate),
    .osc_en(osc_en), .pll_en(pll_en), .mode(mode)
  );

  int total = 0;
  int bad = 0;
  string tag = "R1";
  bit finished = 1'b0;

  // behavioural reference
  int m = 0;
  bit warming = 1'b0;
  int wc = 0;

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    int exp_gate;
    exp_gate = (m <= 1) ? int'(per_clk_en) : 0;
    chk("mode", int'(mode), m);
    chk("cpu_clk_en", int'(cpu_clk_en), (m == 0) ? 1 : 0);
    chk("per_clk_gate", int'(per_clk_gate), exp_gate);
    chk("osc_en", int'(osc_en), (m == 3 && !warming) ? 0 : 1);
    chk("pll_en", int'(pll_en), (m == 3 && !warming) ? 0 : 1);
  endtask

  task automatic model_edge();
    bit live;
    bit cancel;
    live = (per_irq & per_clk_en) != 0;
    if (m == 0) begin
      if (enter && mode_req != 0) begin
        cancel = (mode_req == 1) ? (live || wdog_evt) : ext_wake;
        if (!cancel) m = int'(mode_req);
      end
    end else if (m == 1) begin
      if (live || wdog_evt) m = 0;
    end else if (m == 2) begin
      if (ext_wake) m = 0;
    end else if (!warming) begin
      if (ext_wake) begin warming = 1'b1; wc = 0; end
    end else begin
      wc++;
      if (wc == OSC) begin warming = 1'b0; m = 0; end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    enter = 1'b0; per_irq = '0; wdog_evt = 1'b0; ext_wake = 1'b0;
  endtask

  task automatic go(int lvl);
    mode_req = 2'(lvl); enter = 1'b1;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    #5; compare();
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R3 enter with request 0 stays in RUN
    tag = "R3"; go(0);
    // R3 R4 R2 light sleep entry
    tag = "R4"; go(1); tick();
    // R5 ignored: disabled-clock peripheral, external wake
    tag = "R5";
    per_irq = 4'b0010; tick();
    ext_wake = 1'b1; tick();
    per_irq = 4'b0100; tick();
    go(1);
    wdog_evt = 1'b1; tick();
    // R4 gates follow enables while asleep
    tag = "R4"; go(1); per_clk_en = 4'b1010; tick(); per_irq = 4'b1000; tick();
    per_clk_en = 4'b0101;
    // R10 cancelled entries
    tag = "R10";
    wdog_evt = 1'b1; go(1);
    per_irq = 4'b0001; go(1);
    ext_wake = 1'b1; go(2);
    ext_wake = 1'b1; go(3);
    // R6 R7 medium sleep
    tag = "R6"; go(2); tick();
    tag = "R7";
    wdog_evt = 1'b1; tick();
    per_irq = 4'b1111; tick();
    tag = "R12"; go(3); go(1);
    tag = "R7"; ext_wake = 1'b1; tick();
    // R8 R9 deep sleep
    tag = "R8"; go(3); tick();
    wdog_evt = 1'b1; tick();
    per_irq = 4'b0101; tick();
    tag = "R12"; go(1);
    tag = "R9"; ext_wake = 1'b1; tick();
    for (int i = 0; i < OSC + 2; i++) tick();
    // R2 status again after second deep-sleep cycle with a short hop
    tag = "R2"; go(3); ext_wake = 1'b1; tick();
    for (int i = 0; i < OSC; i++) tick();
    // R11 async reset out of medium sleep
    tag = "R11"; go(2); tick();
    #3 rst_n = 1'b0; m = 0; warming = 1'b0;
    #2 compare();
    @(negedge clk); rst_n = 1'b1;
    tick();
    // R11 async reset out of deep sleep
    go(3);
    #3 rst_n = 1'b0; m = 0; warming = 1'b0;
    #2 compare();
    @(negedge clk); rst_n = 1'b1;
    tick();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule